// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a data cache placed between a processor port and a memory port that moves one 32-bit word at a time. Each line keeps a valid flag, a tag and four data words. Placement is direct-mapped, so every memory line has exactly one slot. A read that misses fetches the whole four-word line into its slot and then finishes as a hit. A write that misses does the same fetch first and then merges the new word into the line. This keeps words from two different memory lines out of a single entry.

Every write updates the cache and is also forwarded to memory. A four-entry write buffer carries these stores, so the processor moves on without waiting for the memory write. Before any line fetch starts, the buffer is drained, so memory never hands back a word older than a store that is still queued. The processor is stalled as a whole while an access is in progress. With the default index width of 8 the cache holds 256 lines (4 KB). An index width of 12 gives the 64 KB configuration.

Top module: `dmwt_cache`

## Requirements
- R1: A processor address is split as follows: bits 1:0 are a byte position that is ignored for data, bits 3:2 pick the word in the line, bits 4+INDEX_W-1:4 pick the line slot, and all bits above form the tag. Accesses are whole 32-bit words.
- R2: Reset clears every valid flag and leaves cpu_stall and mem_req low. The first access to any line after reset misses and fetches four words.
- R3: An access hits only when the slot is valid and its stored tag equals the address tag. A read hit completes with exactly two stall cycles, makes no memory access, and returns the addressed word.
- R4: A read miss issues four memory reads at the line base plus 0, 4, 8 and 12, in that order. It writes the words, the tag and the valid flag into the slot, then completes as a hit with the addressed word.
- R5: Two addresses with the same slot bits and different tags evict each other, so each one misses again after the other has been loaded.
- R6: A write miss fetches the line first and then overwrites only the addressed word. The other three words keep the values fetched from memory.
- R7: Every write is sent to memory with its address and data. A write hit completes with two stall cycles while the write buffer has a free entry.
- R8: The write buffer holds four stores. A write hit that finds it full stalls until an entry frees. Stores reach memory in the order they were issued.
- R9: No memory read is issued while a buffered store is pending. A line fetched after a store to that line returns the stored value.
- R10: A memory request keeps mem_req, mem_we, mem_addr and mem_wdata unchanged until the cycle in which mem_ready is high.
- R11: cpu_stall is high from the first cycle of a request until the access completes. The access completes in the cycle where cpu_req is high and cpu_stall is low, and cpu_rdata holds the read word in that cycle. The processor holds its request fields until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rdata | output | 32 | Read word, valid when the access completes |
| cpu_stall | output | 1 | Processor must wait while high |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ready |
| mem_ready | input | 1 | Memory finishes the current request |

## Verification
On every cycle the assertions check four properties. The memory request stays stable until ready. A read is never issued while buffered stores remain. Nothing is pushed into a full buffer. A new request always sees a stall before it completes. The bench scenarios are needed for the rest: correct line contents after refill, eviction between conflicting tags, merging of a word on a write miss, the ordering of stores at memory, and the extra stall when the buffer fills. These are checked against a shadow memory in the bench and a random mix of reads and writes.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_DRAIN,
    ST_FILL
  } dmwt_state_e;
endpackage

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_q;

  // tag array: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    rd_tag <= tag_mem[rd_idx];
  end

  // valid flags in flops so that reset can clear them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en) valid_q[wr_idx] <= 1'b1;
      rd_valid <= valid_q[rd_idx];
    end
  end
endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dmwt_wbuf.sv
module dmwt_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [AW-1:0]    addr_mem [DEPTH];
  logic [DW-1:0]    data_mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
  import dmwt_pkg::*;
#(
  parameter int INDEX_W    = 8,
  parameter int LINE_WORDS = 4,
  parameter int WB_DEPTH   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 2;
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int TAG_W  = ADDR_W - OFF_W - INDEX_W;
  localparam int RAM_AW = INDEX_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  // address fields
  logic [INDEX_W-1:0] a_idx;
  logic [TAG_W-1:0]   a_tag;
  logic [WSEL_W-1:0]  a_wsel;
  assign a_idx  = cpu_addr[OFF_W +: INDEX_W];
  assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign a_wsel = cpu_addr[BYTE_W +: WSEL_W];

  dmwt_state_e       state_q;
  logic              ack_q;
  logic [WSEL_W-1:0] fill_cnt_q;

  // storage interfaces
  logic              st_valid;
  logic [TAG_W-1:0]  st_tag;
  logic              tag_we;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  // write buffer interfaces
  logic              wb_push, wb_pop, wb_full, wb_empty;
  logic [ADDR_W-1:0] wb_head_addr;
  logic [DATA_W-1:0] wb_head_data;

  // control strobes
  logic hit, in_lookup, in_fill, fill_beat, fill_last, wr_commit;

  always_comb begin
    in_lookup = (state_q == ST_LOOKUP);
    in_fill   = (state_q == ST_FILL);
    hit       = st_valid && (st_tag == a_tag);
    fill_beat = in_fill && mem_ready;
    fill_last = fill_beat && (fill_cnt_q == LAST_WORD);
    wr_commit = in_lookup && cpu_we && hit && !wb_full;
    wb_push   = wr_commit;
    wb_pop    = !in_fill && !wb_empty && mem_ready;
    tag_we    = fill_last;
    ram_addr  = in_fill ? {a_idx, fill_cnt_q} : {a_idx, a_wsel};
    ram_we    = fill_beat || wr_commit;
    ram_wdata = in_fill ? mem_rdata : cpu_wdata;
  end

  // memory port: line fetch owns it during refill, the buffer otherwise
  always_comb begin
    mem_req   = in_fill || !wb_empty;
    mem_we    = !in_fill;
    mem_addr  = in_fill ? {a_tag, a_idx, fill_cnt_q, {BYTE_W{1'b0}}} : wb_head_addr;
    mem_wdata = wb_head_data;
  end

  assign cpu_stall = cpu_req && !ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ack_q      <= 1'b0;
      fill_cnt_q <= '0;
      cpu_rdata  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (ack_q)        ack_q   <= 1'b0;
          else if (cpu_req) state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (!cpu_we) begin
              cpu_rdata <= ram_rdata;
              ack_q     <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (!wb_full) begin
              ack_q     <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end else begin
            state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wb_empty) begin
            fill_cnt_q <= '0;
            state_q    <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
            if (fill_last) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dmwt_tag_store #(
    .INDEX_W(INDEX_W),
    .TAG_W  (TAG_W)
  ) u_tags (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (a_idx),
    .wr_en   (tag_we),
    .wr_idx  (a_idx),
    .wr_tag  (a_tag),
    .rd_valid(st_valid),
    .rd_tag  (st_tag)
  );

  dmwt_data_store #(
    .AW(RAM_AW),
    .DW(DATA_W)
  ) u_data (
    .clk  (clk),
    .addr (ram_addr),
    .we   (ram_we),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  dmwt_wbuf #(
    .DEPTH(WB_DEPTH),
    .AW   (ADDR_W),
    .DW   (DATA_W)
  ) u_wbuf (
    .clk      (clk),
    .rst      (rst),
    .push     (wb_push),
    .push_addr(cpu_addr),
    .push_data(cpu_wdata),
    .pop      (wb_pop),
    .head_addr(wb_head_addr),
    .head_data(wb_head_data),
    .full     (wb_full),
    .empty    (wb_empty)
  );
endmodule

// File: rtl/dmwt_cache_chk.sv
module dmwt_cache_chk (
  input logic        clk,
  input logic        rst,
  input logic        cpu_req,
  input logic        cpu_stall,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        wb_empty,
  input logic        wb_full,
  input logic        wb_push
);
  // R10: request fields held until ready
  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R9: reads only once the store buffer is empty
  assert_drain_first_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> wb_empty);

  // R8: never push into a full buffer
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> !wb_full);

  // R11: a fresh request is stalled before it completes
  assert_stall_on_start_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_req) |-> cpu_stall);

  // R4: line fetch addresses are word aligned
  assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));
endmodule

bind dmwt_cache dmwt_cache_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_req  (cpu_req),
  .cpu_stall(cpu_stall),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_ready(mem_ready),
  .wb_empty (wb_empty),
  .wb_full  (wb_full),
  .wb_push  (wb_push)
);

// File: tb/dmwt_cache_bench.sv
module dmwt_cache_bench;
  localparam int LAT = 15;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dmwt_cache u_dmwt_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  function automatic logic [31:0] init_word(input int i);
    return (i * 32'h9E37_79B1) ^ 32'hA5A5_0000;
  endfunction

  // memory model: LAT cycles per access, logs every handshake
  logic [31:0] mem_arr [4096];
  logic [31:0] exp_arr [4096];
  int          mcnt;
  int          rd_cnt, wr_cnt;
  logic [31:0] rd_log  [8];
  logic [31:0] wr_alog [16];
  logic [31:0] wr_dlog [16];

  always @(posedge clk) begin
    if (rst) begin
      mem_ready <= 1'b0;
      mem_rdata <= '0;
      mcnt      <= 0;
      rd_cnt    <= 0;
      wr_cnt    <= 0;
      for (int i = 0; i < 4096; i++) mem_arr[i] <= init_word(i);
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      mcnt      <= 0;
    end else if (mem_req) begin
      if (mcnt == LAT - 1) begin
        mem_ready <= 1'b1;
        mcnt      <= 0;
        if (mem_we) begin
          mem_arr[mem_addr[13:2]] <= mem_wdata;
          wr_alog[wr_cnt % 16]    <= mem_addr;
          wr_dlog[wr_cnt % 16]    <= mem_wdata;
          wr_cnt                  <= wr_cnt + 1;
        end else begin
          mem_rdata           <= mem_arr[mem_addr[13:2]];
          rd_log[rd_cnt % 8]  <= mem_addr;
          rd_cnt              <= rd_cnt + 1;
        end
      end else begin
        mcnt <= mcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] rdv;
  int          st;

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    st = 0;
    #1;
    while (cpu_stall) begin
      st++;
      @(negedge clk);
    end
    rdv = cpu_rdata;
    cpu_req = 1'b0;
    if (we) exp_arr[a[13:2]] = d;
  endtask

  task automatic wait_mem_idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
  endtask

  int r0, w0;
  logic [31:0] base;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 4096; i++) exp_arr[i] = init_word(i);
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    chk(!cpu_stall && !mem_req, "R2 reset idle", {30'd0, cpu_stall, mem_req}, 32'd0);

    // R4/R2: cold read miss fetches ascending line words
    r0 = rd_cnt;
    access(0, 32'h0000_0124, 0);
    chk(rdv == exp_arr[12'h049], "R4 read miss data", rdv, exp_arr[12'h049]);
    chk(rd_cnt - r0 == 4, "R2 cold miss four reads", rd_cnt - r0, 4);
    base = 32'h0000_0120;
    for (int k = 0; k < 4; k++)
      chk(rd_log[(rd_cnt - 4 + k) % 8] == base + 4 * k, "R4 fetch order",
          rd_log[(rd_cnt - 4 + k) % 8], base + 4 * k);

    // R1/R3: other word of the same line, byte bits ignored, is a hit
    r0 = rd_cnt;
    access(0, 32'h0000_012B, 0);
    chk(rdv == exp_arr[12'h04A], "R1 word select", rdv, exp_arr[12'h04A]);
    chk(rd_cnt == r0, "R3 hit no memory read", rd_cnt - r0, 0);
    chk(st == 2, "R3 R11 hit stall cycles", st, 2);

    // R5: conflicting tag evicts
    r0 = rd_cnt;
    access(0, 32'h0000_1124, 0);
    chk(rdv == exp_arr[12'h449], "R5 conflict data", rdv, exp_arr[12'h449]);
    chk(rd_cnt - r0 == 4, "R5 conflict miss", rd_cnt - r0, 4);
    r0 = rd_cnt;
    access(0, 32'h0000_0124, 0);
    chk(rd_cnt - r0 == 4, "R5 evicted line misses again", rd_cnt - r0, 4);

    // R7: write hit forwarded to memory
    w0 = wr_cnt;
    access(1, 32'h0000_0124, 32'hDEAD_0001);
    chk(st == 2, "R7 write hit stall cycles", st, 2);
    wait_mem_idle();
    chk(wr_cnt - w0 == 1, "R7 one memory write", wr_cnt - w0, 1);
    chk(wr_alog[w0 % 16][13:2] == 12'h049 && wr_dlog[w0 % 16] == 32'hDEAD_0001,
        "R7 write address and data", wr_dlog[w0 % 16], 32'hDEAD_0001);
    access(0, 32'h0000_0124, 0);
    chk(rdv == 32'hDEAD_0001, "R7 cache updated", rdv, 32'hDEAD_0001);

    // R6: write miss fetches then merges
    r0 = rd_cnt; w0 = wr_cnt;
    access(1, 32'h0000_2344, 32'hBEEF_0006);
    chk(rd_cnt - r0 == 4, "R6 write miss fetch", rd_cnt - r0, 4);
    access(0, 32'h0000_2344, 0);
    chk(rdv == 32'hBEEF_0006, "R6 merged word", rdv, 32'hBEEF_0006);
    access(0, 32'h0000_2340, 0);
    chk(rdv == exp_arr[12'h8D0], "R6 neighbour word kept", rdv, exp_arr[12'h8D0]);
    wait_mem_idle();
    chk(wr_cnt - w0 == 1, "R6 write miss sent to memory", wr_cnt - w0, 1);

    // R8: buffer fills after four stores
    access(0, 32'h0000_0500, 0);
    wait_mem_idle();
    w0 = wr_cnt;
    for (int k = 0; k < 5; k++) begin
      access(1, 32'h0000_0500 + 4 * (k % 4), 32'hC0DE_0000 + k);
      if (k < 4) chk(st == 2, "R8 store accepted", st, 2);
      else       chk(st > 2, "R8 full buffer stalls", st, 3);
    end
    wait_mem_idle();
    chk(wr_cnt - w0 == 5, "R8 store count", wr_cnt - w0, 5);
    for (int k = 0; k < 5; k++)
      chk(wr_alog[(w0 + k) % 16] == 32'h0000_0500 + 4 * (k % 4) &&
          wr_dlog[(w0 + k) % 16] == 32'hC0DE_0000 + k,
          "R8 store order", wr_dlog[(w0 + k) % 16], 32'hC0DE_0000 + k);

    // R9: store, evict, refetch must see the stored word
    access(0, 32'h0000_0780, 0);
    access(1, 32'h0000_0788, 32'h5A5A_0009);
    access(0, 32'h0000_1780, 0);
    access(0, 32'h0000_0788, 0);
    chk(rdv == 32'h5A5A_0009, "R9 refetch after drain", rdv, 32'h5A5A_0009);

    // random mix against shadow memory
    void'($urandom(32'd7919));
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      a = ($urandom % 4096) << 2;
      if (($urandom % 10) < 3) begin
        access(1, a, $urandom);
      end else begin
        access(0, a, 0);
        chk(rdv == exp_arr[a[13:2]], "R3 R4 random read", rdv, exp_arr[a[13:2]]);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule